// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog that software programs through a small 16-bit register port. The countdown advances on a slow, externally supplied tick strobe with a nominal 2 Hz rate, so each tick is half a second. The reload value is an 8-bit field in the control register. Software keeps the system alive by writing two fixed key words, in order, to the service register. If the counter runs out, the block records a timeout in its reset-status register and raises a system-reset request that stays high until the next reset. Certain control writes raise the same request at once. A control write can also log a software-reset event.

Some control bits protect themselves. The enable bit and the timeout-configuration bit stay set once written as 1. Every control write stops the countdown and restarts it from the value just written.

Top module: `wdg_top`

## Requirements
- R1: After reset, control reads 16'h0030 (assertion-select bit 5 and software-reset bit 4 set), service reads 0, reset-status reads 0, misc-control reads 16'h0001, and `rstReq` and `timeoutStatus` are low. Offsets are 0x0 control, 0x2 service, 0x4 reset-status, 0x6 reserved interrupt-control and 0x8 misc-control.
- R2: The timeout field is control bits 15:8. A field value N expires on the (N+1)-th clock edge with `tickEn` high after the control write. Edges with `tickEn` low do not count. This holds up to N = 255, which gives 256 ticks.
- R3: The counter runs only while the enable bit (control bit 2) is 1 and the timeout field is nonzero. Otherwise ticks have no effect.
- R4: Every control write stops the counter and restarts it from the newly written field value.
- R5: A service-register write of 16'hAAAA reloads the counter to field+1 only when the service register held 16'h5555 before that write. Every service write is stored and reads back.
- R6: Once the enable bit (bit 2) or the configuration bit (bit 3) has been written as 1, later control writes cannot clear it.
- R7: A control write with bit 4 at 0 sets reset-status to exactly 16'h0001 (the software-reset flag). Bit 4 of control always reads back as 1.
- R8: A control write in which both bit 5 and bit 4 are 0 raises `rstReq` at once. So does a control write whose resulting enable bit is 1 with a timeout field of 0.
- R9: On expiry, reset-status becomes exactly 16'h0002 (timeout flag, bit 1), `timeoutStatus` goes high and `rstReq` rises. `rstReq` then stays high until reset.
- R10: Writes to reset-status and to offset 0x6 have no effect, and offset 0x6 reads 0. Misc-control keeps only bit 0 of a written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Half-second tick strobe, one clock wide per tick |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register byte offset |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| rstReq | output | 1 | Sticky system-reset request |
| timeoutStatus | output | 1 | Timeout flag from reset-status |

## Verification
The assertions assume that `tickEn` and `wrEn` are single-cycle synchronous strobes and that `addr` holds one of the decoded offsets whenever `wrEn` is high. The decrement property excludes every cycle that carries a write, because a write may legally reload the count. The stimulus drives all inputs on the falling clock edge and holds each write for exactly one rising edge. It uses only the documented offsets, and it pulses reset between scenarios because `rstReq` can only be cleared by reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  // control bit positions (timeout field sits in the top byte)
  localparam int EN_BIT  = 2;
  localparam int CFG_BIT = 3;
  localparam int SWR_BIT = 4;
  localparam int AST_BIT = 5;
  // reset-status flag positions
  localparam int SWF_BIT = 0;
  localparam int TOF_BIT = 1;
  // misc-control
  localparam int PDE_BIT = 0;
  // register byte offsets
  localparam int OFF_CTRL = 0;
  localparam int OFF_SVC  = 2;
  localparam int OFF_STAT = 4;
  localparam int OFF_IRQ  = 6;
  localparam int OFF_MISC = 8;

  typedef enum logic [2:0] {
    SEL_CTRL, SEL_SVC, SEL_STAT, SEL_IRQ, SEL_MISC, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic load;    // load counter with loadVal+1
    logic setRun;  // start running with the load
    logic clrRun;  // stop with the load
    logic dec;     // tick strobe
  } cntCmd_t;
endpackage

// File: rtl/wdg_count.sv
module wdg_count
  import wdg_pkg::*;
#(
  parameter int TO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cntCmd_t           cmd,
  input  logic [TO_W-1:0]   loadVal,
  output logic [TO_W:0]     countVal,
  output logic              runFlag,
  output logic              expireHit
);
  localparam int CNT_W = TO_W + 1;

  logic [CNT_W-1:0] countQ;
  logic             runQ;

  // a load in the same cycle wins over an expiry
  assign expireHit = runQ && cmd.dec && !cmd.load && (countQ == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
      runQ   <= 1'b0;
    end else if (cmd.load) begin
      countQ <= {1'b0, loadVal} + CNT_W'(1);
      if (cmd.setRun)      runQ <= 1'b1;
      else if (cmd.clrRun) runQ <= 1'b0;
    end else if (expireHit) begin
      countQ <= '0;
      runQ   <= 1'b0;
    end else if (runQ && cmd.dec) begin
      countQ <= countQ - CNT_W'(1);
    end
  end

  assign countVal = countQ;
  assign runFlag  = runQ;
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int              DATA_W = 16,
  parameter int              ADDR_W = 4,
  parameter int              TO_W   = 8,
  parameter logic [DATA_W-1:0] KEY_A = 16'h5555,
  parameter logic [DATA_W-1:0] KEY_B = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expireHit,
  output cntCmd_t           cmd,
  output logic [TO_W-1:0]   loadVal,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq,
  output logic [DATA_W-1:0] ctrlQ,
  output logic [DATA_W-1:0] statusQ
);
  localparam int          TO_LSB   = DATA_W - TO_W;
  localparam logic [DATA_W-1:0] CTRL_RST = (DATA_W'(1) << SWR_BIT) | (DATA_W'(1) << AST_BIT);
  localparam logic [DATA_W-1:0] MISC_MSK = DATA_W'(1) << PDE_BIT;

  regSel_e           sel;
  logic [DATA_W-1:0] svcQ, miscQ, ctrlR, statR;
  logic [DATA_W-1:0] nextCtrl;
  logic [TO_W-1:0]   newField, curField;
  logic              ctrlWr, svcWr, miscWr;
  logic              wantRun, curRun, svcMatch, immReset, rstReqQ;

  always_comb begin
    unique case (addr)
      ADDR_W'(OFF_CTRL): sel = SEL_CTRL;
      ADDR_W'(OFF_SVC):  sel = SEL_SVC;
      ADDR_W'(OFF_STAT): sel = SEL_STAT;
      ADDR_W'(OFF_IRQ):  sel = SEL_IRQ;
      ADDR_W'(OFF_MISC): sel = SEL_MISC;
      default:           sel = SEL_NONE;
    endcase
  end

  assign ctrlWr = wrEn && (sel == SEL_CTRL);
  assign svcWr  = wrEn && (sel == SEL_SVC);
  assign miscWr = wrEn && (sel == SEL_MISC);

  // sticky bits: once set in the register they override the written value
  always_comb begin
    nextCtrl = wrData;
    if (ctrlR[EN_BIT])  nextCtrl[EN_BIT]  = 1'b1;
    if (ctrlR[CFG_BIT]) nextCtrl[CFG_BIT] = 1'b1;
  end

  assign newField = nextCtrl[DATA_W-1:TO_LSB];
  assign curField = ctrlR[DATA_W-1:TO_LSB];
  assign wantRun  = nextCtrl[EN_BIT] && (newField != '0);
  assign curRun   = ctrlR[EN_BIT] && (curField != '0);
  assign svcMatch = svcWr && (svcQ == KEY_A) && (wrData == KEY_B);
  assign immReset = ctrlWr &&
                    ((!nextCtrl[SWR_BIT] && !nextCtrl[AST_BIT]) ||
                     (nextCtrl[EN_BIT] && (newField == '0)));

  always_comb begin
    cmd.load   = ctrlWr || (svcMatch && curRun);
    cmd.setRun = ctrlWr && wantRun;
    cmd.clrRun = ctrlWr && !wantRun;
    cmd.dec    = tickEn;
    loadVal    = ctrlWr ? newField : curField;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlR   <= CTRL_RST;
      statR   <= '0;
      svcQ    <= '0;
      miscQ   <= MISC_MSK;
      rstReqQ <= 1'b0;
    end else begin
      if (ctrlWr) ctrlR <= nextCtrl | (DATA_W'(1) << SWR_BIT);
      if (ctrlWr && !wrData[SWR_BIT]) statR <= DATA_W'(1) << SWF_BIT;
      else if (expireHit)             statR <= DATA_W'(1) << TOF_BIT;
      if (svcWr)  svcQ  <= wrData;
      if (miscWr) miscQ <= wrData & MISC_MSK;
      if (immReset || (expireHit && ctrlR[EN_BIT])) rstReqQ <= 1'b1;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: rdData = ctrlR;
      SEL_SVC:  rdData = svcQ;
      SEL_STAT: rdData = statR;
      SEL_MISC: rdData = miscQ;
      default:  rdData = '0;
    endcase
  end

  assign rstReq  = rstReqQ;
  assign ctrlQ   = ctrlR;
  assign statusQ = statR;
endmodule

// File: rtl/wdg_top.sv
module wdg_top
  import wdg_pkg::*;
#(
  parameter int                DATA_W = 16,
  parameter int                ADDR_W = 4,
  parameter int                TO_W   = 8,
  parameter logic [DATA_W-1:0] KEY_A  = 16'h5555,
  parameter logic [DATA_W-1:0] KEY_B  = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rstReq,
  output logic              timeoutStatus
);
  cntCmd_t           cmd;
  logic [TO_W-1:0]   loadVal;
  logic [TO_W:0]     countVal;
  logic              runFlag, expireHit;
  logic [DATA_W-1:0] ctrlQ, statusQ;

  wdg_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TO_W(TO_W), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .expireHit(expireHit), .cmd(cmd), .loadVal(loadVal),
    .rdData(rdData), .rstReq(rstReq), .ctrlQ(ctrlQ), .statusQ(statusQ)
  );

  wdg_count #(.TO_W(TO_W)) count_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .loadVal(loadVal),
    .countVal(countVal), .runFlag(runFlag), .expireHit(expireHit)
  );

  assign timeoutStatus = statusQ[TOF_BIT];
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
  import wdg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TO_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tickEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] ctrlQ,
  input logic [DATA_W-1:0] statusQ,
  input logic [TO_W:0]     countVal,
  input logic              runFlag,
  input logic              expireHit,
  input logic              rstReq
);
  localparam int TO_LSB = DATA_W - TO_W;

  AST_RUN_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    runFlag |-> (ctrlQ[EN_BIT] && (ctrlQ[DATA_W-1:TO_LSB] != '0))); // R3
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    runFlag |-> (countVal != '0)); // R2
  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (runFlag && tickEn && !wrEn && (countVal > (TO_W+1)'(1))) |=>
      (countVal == $past(countVal) - (TO_W+1)'(1))); // R2
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlQ[EN_BIT] |=> ctrlQ[EN_BIT]); // R6
  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlQ[CFG_BIT] |=> ctrlQ[CFG_BIT]); // R6
  AST_SWR_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlQ[SWR_BIT]); // R7
  AST_EXPIRE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    expireHit |=> ((statusQ == (DATA_W'(1) << TOF_BIT)) && rstReq)); // R9
  AST_RSTREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rstReq |=> rstReq); // R9
endmodule

bind wdg_top wdg_chk #(.DATA_W(DATA_W), .TO_W(TO_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .ctrlQ(ctrlQ),
  .statusQ(statusQ), .countVal(countVal), .runFlag(runFlag),
  .expireHit(expireHit), .rstReq(rstReq)
);

// File: tb/wdg_top_tb.sv
module wdg_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;
  // vector: {req[3:0], isRead, addr[3:0], data[15:0]}
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  1'b1, 4'h0, 16'h0030},  // R1 control reset value
    {4'd1,  1'b1, 4'h2, 16'h0000},  // R1 service reset value
    {4'd1,  1'b1, 4'h4, 16'h0000},  // R1 status reset value
    {4'd1,  1'b1, 4'h8, 16'h0001},  // R1 misc reset value
    {4'd10, 1'b0, 4'h4, 16'hFFFF},  // R10 status write ignored
    {4'd10, 1'b1, 4'h4, 16'h0000},
    {4'd10, 1'b0, 4'h8, 16'hFFFE},  // R10 misc keeps bit 0 only
    {4'd10, 1'b1, 4'h8, 16'h0000},
    {4'd10, 1'b0, 4'h8, 16'hFFFF},
    {4'd10, 1'b1, 4'h8, 16'h0001},
    {4'd10, 1'b0, 4'h6, 16'hFFFF},  // R10 reserved offset
    {4'd10, 1'b1, 4'h6, 16'h0000},
    {4'd7,  1'b0, 4'h0, 16'h0020},  // R7 software reset bit low
    {4'd7,  1'b1, 4'h4, 16'h0001},
    {4'd7,  1'b1, 4'h0, 16'h0030},
    {4'd6,  1'b0, 4'h0, 16'h0338},  // R6 config bit set
    {4'd6,  1'b1, 4'h0, 16'h0338},
    {4'd6,  1'b0, 4'h0, 16'h0330},
    {4'd6,  1'b1, 4'h0, 16'h0338},
    {4'd6,  1'b0, 4'h0, 16'h0334},  // R6 enable set
    {4'd6,  1'b0, 4'h0, 16'h0330},
    {4'd6,  1'b1, 4'h0, 16'h033C},
    {4'd5,  1'b0, 4'h2, 16'h1234},  // R5 service stores any value
    {4'd5,  1'b1, 4'h2, 16'h1234}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        rstReq, timeoutStatus;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_top dut_i (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rstReq(rstReq), .timeoutStatus(timeoutStatus)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [3:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); addr = a;
    #1 chk(req, rdData, exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    chk("R1 rstReq", {15'd0, rstReq}, 16'd0);
    chk("R1 timeoutStatus", {15'd0, timeoutStatus}, 16'd0);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) rdChk(VEC[i][19:16], VEC[i][15:0], $sformatf("R%0d vec%0d", VEC[i][24:21], i));
      else            doWrite(VEC[i][19:16], VEC[i][15:0]);
    end

    // R2 expiry after N+1 ticks, gaps without tickEn ignored
    doReset();
    doWrite(4'h0, 16'h0334);
    ticks(2); repeat (5) @(negedge clk); ticks(1);
    chk("R2 no expiry after N ticks", {15'd0, rstReq}, 16'd0);
    chk("R9 timeoutStatus low", {15'd0, timeoutStatus}, 16'd0);
    ticks(1);
    chk("R2 expiry at N+1", {15'd0, rstReq}, 16'd1);
    chk("R9 timeoutStatus", {15'd0, timeoutStatus}, 16'd1);
    rdChk(4'h4, 16'h0002, "R9 status exact");
    ticks(3); doWrite(4'h0, 16'h0334);
    chk("R9 rstReq held", {15'd0, rstReq}, 16'd1);

    // R2 max field 255
    doReset();
    doWrite(4'h0, 16'hFF34);
    ticks(255);
    chk("R2 max no expiry at 255", {15'd0, rstReq}, 16'd0);
    ticks(1);
    chk("R2 max expiry at 256", {15'd0, rstReq}, 16'd1);

    // R3 disabled counter ignores ticks
    doReset();
    doWrite(4'h0, 16'h0330);
    ticks(10);
    chk("R3 disabled no reset", {15'd0, rstReq}, 16'd0);
    rdChk(4'h4, 16'h0000, "R3 status untouched");

    // R4 control write restarts
    doReset();
    doWrite(4'h0, 16'h0334);
    ticks(3);
    doWrite(4'h0, 16'h0334);
    ticks(3);
    chk("R4 restart no expiry", {15'd0, rstReq}, 16'd0);
    ticks(1);
    chk("R4 restart expiry", {15'd0, rstReq}, 16'd1);

    // R5 correct key pair reloads
    doReset();
    doWrite(4'h0, 16'h0534);
    ticks(4);
    doWrite(4'h2, 16'h5555); doWrite(4'h2, 16'hAAAA);
    rdChk(4'h2, 16'hAAAA, "R5 service readback");
    ticks(5);
    chk("R5 reload holds off", {15'd0, rstReq}, 16'd0);
    ticks(1);
    chk("R5 expiry after reload", {15'd0, rstReq}, 16'd1);

    // R5 broken key pair does not reload
    doReset();
    doWrite(4'h0, 16'h0534);
    ticks(4);
    doWrite(4'h2, 16'h5555); doWrite(4'h2, 16'h1234); doWrite(4'h2, 16'hAAAA);
    ticks(1);
    chk("R5 broken seq one left", {15'd0, rstReq}, 16'd0);
    ticks(1);
    chk("R5 broken seq expiry", {15'd0, rstReq}, 16'd1);

    // R8 immediate requests
    doReset();
    doWrite(4'h0, 16'h0000);
    chk("R8 both select bits low", {15'd0, rstReq}, 16'd1);
    doReset();
    doWrite(4'h0, 16'h0034);
    chk("R8 enable with zero field", {15'd0, rstReq}, 16'd1);
    doReset();
    doWrite(4'h0, 16'h0334);
    doWrite(4'h0, 16'h0030);
    chk("R8 R6 sticky enable zero field", {15'd0, rstReq}, 16'd1);
    doReset();
    doWrite(4'h0, 16'h0310);
    chk("R8 single select bit low no request", {15'd0, rstReq}, 16'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule